// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of up to sixteen transfers held in local storage, with no help from the host between words. Each list entry holds a word to send, a slot for the word received, and a command byte. The command byte gives the levels of the four chip-select lines for that transfer, and says whether the selects stay asserted into the next entry.

The host loads the transmit words and command bytes through a small register port. It sets the first and last entry of the run, the bit rate, the clock mode and the word size, and then writes a start bit. The sequencer steps an entry pointer from the first entry to the last, wrapping from 15 to 0. Each entry is shifted out most significant bit first while the data-in line is sampled. The received word goes into the entry's receive slot. When the pointer has matched the last entry and that transfer has finished, the run stops and the done flag is set. The host then reads back the received words.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, the status register reads 0, spi_sck is 0, spi_mosi is 0 and spi_cs is 4'hF. The configuration register reads 0 and the queue register reads 16'h0F00.
- R2: While an entry is being transferred, spi_cs equals bits [3:0] of that entry's command byte. Several lines may be asserted at once.
- R3: Configuration bit 10 selects 16-bit words (1) or 8-bit words (0). An 8-bit entry sends bits [7:0] of its transmit word. Every word leaves spi_mosi most significant bit first, with exactly 8 or 16 sample edges per entry.
- R4: The word sampled on spi_miso, most significant bit first, is written to the receive slot of the same entry. In 8-bit mode it lands in bits [7:0] and bits [15:8] read 0.
- R5: A run processes the entries from the start pointer (queue register bits [3:0]) to the end pointer (bits [7:4]) inclusive, wrapping from 15 to 0. It then returns spi_cs to the idle levels (bits [11:8]), clears busy and sets done in the same cycle.
- R6: Each half period of spi_sck lasts 2 × BAUD system clocks, where BAUD is configuration bits [7:0]. A start request while BAUD is 0 is ignored: busy stays 0 and done keeps its value.
- R7: Configuration bit 8 (CPOL) sets the resting level of spi_sck. Bit 9 (CPHA) selects sampling on the leading edge (0) or the trailing edge (1), with data changing on the other edge. All four modes are supported.
- R8: Command bit 4 set keeps the chip selects driven from one entry into the next. When it is clear, spi_cs returns to the idle levels for one half period before the next entry.
- R9: Register map, 6-bit address: 0x00–0x0F transmit words, 0x10–0x1F receive words (read only), 0x20–0x2F command bytes, 0x30 configuration, 0x31 queue. At 0x32, a write with bit 0 set starts a run and clears done; a read returns {busy, done} in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register / entry address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines, levels per entry |

## Verification
The queue is run in all four clock modes, crossed with both word sizes, and several bit rates. The tests use full runs, partial runs, a run that wraps past entry 15, and a single-entry run. The wrap and single-entry runs separate the pointer comparison from a plain count. The two word sizes show whether the MSB-first order and the receive-slot alignment are correct. Transmit words, reply words and select patterns change from entry to entry, so a swapped slot or an off-by-one bit shows up. A mix of set and clear continue bits separates held selects from selects returned to idle. A start request with a zero rate checks that the start is refused.

// File: rtl/spiq_pkg.sv
`timescale 1ns/1ps
package spiq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_XFER = 2'd2,
    SQ_GAP  = 2'd3
  } sq_state_t;

  localparam int unsigned CMD_W = 8;
endpackage

// File: rtl/spiq_baud.sv
`timescale 1ns/1ps
module spiq_baud #(
  parameter int unsigned BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  localparam logic [BAUD_W-1:0] ONE = BAUD_W'(1);

  logic              ph_q, ph_d;
  logic [BAUD_W-1:0] cnt_q, cnt_d;

  // half-rate enable, then divide by the rate value
  always_comb begin
    tick  = run && ph_q && (cnt_q == baud - ONE);
    ph_d  = 1'b0;
    cnt_d = '0;
    if (run) begin
      ph_d  = ~ph_q;
      cnt_d = cnt_q;
      if (ph_q) cnt_d = tick ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spiq_shift.sv
`timescale 1ns/1ps
module spiq_shift #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en,
  input  logic          tick,
  input  logic [DW-1:0] tx_word,
  input  logic          wide,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic [DW-1:0] rx_word,
  output logic          fin
);
  localparam int unsigned CW = $clog2(2 * DW + 2);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d, n_edges;
  logic          sck_q, sck_d;
  logic          is_edge, lead, do_smp, do_shf;

  // tick 0: setup, ticks 1..2n: clock edges, tick 2n+1: hold and finish
  always_comb begin
    n_edges = wide ? CW'(2 * DW) : CW'(DW);
    is_edge = (cnt_q != '0) && (cnt_q <= n_edges);
    lead    = cnt_q[0];
    do_smp  = is_edge && (cpha ? !lead : lead);
    do_shf  = is_edge && (cpha ? (lead && cnt_q != CW'(1)) : !lead);
    fin     = en && tick && (cnt_q == n_edges + CW'(1));
    tx_d  = tx_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (load) begin
      tx_d  = wide ? tx_word : {tx_word[HW-1:0], {HW{1'b0}}};
      rx_d  = '0;
      cnt_d = '0;
      sck_d = cpol;
    end else if (en && tick) begin
      cnt_d = cnt_q + CW'(1);
      if (is_edge) sck_d = ~sck_q;
      if (do_smp)  rx_d  = {rx_q[DW-2:0], miso};
      if (do_shf)  tx_d  = {tx_q[DW-2:0], 1'b0};
    end else if (!en) begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[DW-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spiq_seq.sv
`timescale 1ns/1ps
module spiq_seq
  import spiq_pkg::*;
#(
  parameter int unsigned PTR_W = 4,
  parameter int unsigned CSW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             rate_ok,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic [CSW-1:0]   cs_idle,
  input  logic [CSW-1:0]   cmd_cs,
  input  logic             cmd_cont,
  input  logic             tick,
  input  logic             xfer_fin,
  output logic [PTR_W-1:0] ptr,
  output logic [CSW-1:0]   cs,
  output logic             load,
  output logic             in_xfer,
  output logic             rx_we,
  output logic             busy,
  output logic             done
);
  localparam logic [PTR_W-1:0] PONE = PTR_W'(1);

  sq_state_t        st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CSW-1:0]   cs_q, cs_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cs_d   = cs_q;
    done_d = done_q;
    load   = 1'b0;
    rx_we  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        cs_d = cs_idle;
        if (go && rate_ok) begin
          st_d   = SQ_LOAD;
          ptr_d  = start_ptr;
          done_d = 1'b0;
        end
      end
      SQ_LOAD: begin
        load = 1'b1;
        cs_d = cmd_cs;
        st_d = SQ_XFER;
      end
      SQ_XFER: begin
        if (xfer_fin) begin
          rx_we = 1'b1;
          if (ptr_q == end_ptr) begin
            st_d   = SQ_IDLE;
            cs_d   = cs_idle;
            done_d = 1'b1;
          end else begin
            ptr_d = ptr_q + PONE;
            if (cmd_cont) begin
              st_d = SQ_LOAD;
            end else begin
              st_d = SQ_GAP;
              cs_d = cs_idle;
            end
          end
        end
      end
      SQ_GAP: begin
        if (tick) st_d = SQ_LOAD;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ptr_q  <= '0;
      cs_q   <= '1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cs_q   <= cs_d;
      done_q <= done_d;
    end
  end

  assign ptr     = ptr_q;
  assign cs      = cs_q;
  assign in_xfer = (st_q == SQ_XFER);
  assign busy    = (st_q != SQ_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/spi_queue_master.sv
`timescale 1ns/1ps
module spi_queue_master
  import spiq_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned CSW     = 4,
  parameter int unsigned BAUD_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [$clog2(ENTRIES)+1:0]        reg_addr,
  input  logic [DW-1:0]                     reg_wdata,
  output logic [DW-1:0]                     reg_rdata,
  output logic                              spi_sck,
  output logic                              spi_mosi,
  input  logic                              spi_miso,
  output logic [CSW-1:0]                    spi_cs
);
  localparam int unsigned PTR_W  = $clog2(ENTRIES);
  localparam int unsigned AW     = PTR_W + 2;
  localparam int unsigned B_CPOL = BAUD_W;
  localparam int unsigned B_CPHA = BAUD_W + 1;
  localparam int unsigned B_WIDE = BAUD_W + 2;
  localparam int unsigned Q_END  = PTR_W;
  localparam int unsigned Q_IDLE = 2 * PTR_W;

  logic [DW-1:0]    tx_mem  [ENTRIES];
  logic [DW-1:0]    rx_mem  [ENTRIES];
  logic [CMD_W-1:0] cmd_mem [ENTRIES];

  logic [BAUD_W-1:0] baud_q;
  logic              cpol_q, cpha_q, wide_q;
  logic [PTR_W-1:0]  start_q, end_q;
  logic [CSW-1:0]    cs_idle_q;

  logic [1:0]        region;
  logic [PTR_W-1:0]  idx;
  logic              cfg_we, que_we, go;
  logic [PTR_W-1:0]  ptr;
  logic              load, in_xfer, rx_we, busy, done, tick, fin;
  logic [DW-1:0]     rx_word;
  logic [CMD_W-1:0]  cmd_cur;

  assign region  = reg_addr[AW-1 -: 2];
  assign idx     = reg_addr[PTR_W-1:0];
  assign cfg_we  = reg_we && region == 2'd3 && idx == PTR_W'(0);
  assign que_we  = reg_we && region == 2'd3 && idx == PTR_W'(1);
  assign go      = reg_we && region == 2'd3 && idx == PTR_W'(2) && reg_wdata[0];
  assign cmd_cur = cmd_mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q    <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      wide_q    <= 1'b0;
      start_q   <= '0;
      end_q     <= '0;
      cs_idle_q <= '1;
    end else begin
      if (cfg_we) begin
        baud_q <= reg_wdata[BAUD_W-1:0];
        cpol_q <= reg_wdata[B_CPOL];
        cpha_q <= reg_wdata[B_CPHA];
        wide_q <= reg_wdata[B_WIDE];
      end
      if (que_we) begin
        start_q   <= reg_wdata[PTR_W-1:0];
        end_q     <= reg_wdata[Q_END +: PTR_W];
        cs_idle_q <= reg_wdata[Q_IDLE +: CSW];
      end
    end
  end

  // entry storage, one write enable per array
  always_ff @(posedge clk) begin
    if (reg_we && region == 2'd0) tx_mem[idx] <= reg_wdata;
    if (reg_we && region == 2'd2) cmd_mem[idx] <= reg_wdata[CMD_W-1:0];
    if (rx_we) rx_mem[ptr] <= rx_word;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (region)
      2'd0: reg_rdata = tx_mem[idx];
      2'd1: reg_rdata = rx_mem[idx];
      2'd2: reg_rdata = DW'(cmd_mem[idx]);
      default: begin
        if (idx == PTR_W'(0)) begin
          reg_rdata[BAUD_W-1:0] = baud_q;
          reg_rdata[B_CPOL]     = cpol_q;
          reg_rdata[B_CPHA]     = cpha_q;
          reg_rdata[B_WIDE]     = wide_q;
        end else if (idx == PTR_W'(1)) begin
          reg_rdata[PTR_W-1:0]      = start_q;
          reg_rdata[Q_END +: PTR_W] = end_q;
          reg_rdata[Q_IDLE +: CSW]  = cs_idle_q;
        end else if (idx == PTR_W'(2)) begin
          reg_rdata[1:0] = {busy, done};
        end
      end
    endcase
  end

  spiq_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .baud(baud_q), .tick(tick)
  );

  spiq_seq #(.PTR_W(PTR_W), .CSW(CSW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .rate_ok(baud_q != '0),
    .start_ptr(start_q), .end_ptr(end_q), .cs_idle(cs_idle_q),
    .cmd_cs(cmd_cur[CSW-1:0]), .cmd_cont(cmd_cur[CSW]), .tick(tick),
    .xfer_fin(fin), .ptr(ptr), .cs(spi_cs), .load(load), .in_xfer(in_xfer),
    .rx_we(rx_we), .busy(busy), .done(done)
  );

  spiq_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .en(in_xfer), .tick(tick),
    .tx_word(tx_mem[ptr]), .wide(wide_q), .cpol(cpol_q), .cpha(cpha_q),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .rx_word(rx_word),
    .fin(fin)
  );
endmodule

// File: rtl/spiq_checker.sv
`timescale 1ns/1ps
module spiq_checker #(
  parameter int unsigned CSW    = 4,
  parameter int unsigned BAUD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tick,
  input logic              in_xfer,
  input logic              cpol,
  input logic              spi_sck,
  input logic [CSW-1:0]    spi_cs,
  input logic [CSW-1:0]    cs_idle,
  input logic [BAUD_W-1:0] baud
);
  assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && $past(in_xfer)) |-> $stable(spi_cs));

  assert_stop_idle_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs == cs_idle);

  assert_done_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_start_needs_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud) != '0);

  assert_sck_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && spi_sck != $past(spi_sck)) |-> $past(tick));

  assert_sck_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> spi_sck == cpol);
endmodule

bind spi_queue_master spiq_checker #(.CSW(CSW), .BAUD_W(BAUD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tick(tick),
  .in_xfer(in_xfer), .cpol(cpol_q), .spi_sck(spi_sck), .spi_cs(spi_cs),
  .cs_idle(cs_idle_q), .baud(baud_q)
);

// File: tb/spi_queue_master_tb.sv
`timescale 1ns/1ps
module spi_queue_master_tb_top;
  logic        clk, rst_n, reg_we;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        sck, mosi, miso;
  logic [3:0]  cs;

  int n_chk = 0;
  int n_bad = 0;

  spi_queue_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // slave model state
  bit          active = 1'b0;
  bit          m_cpol, m_cpha;
  int          w, smp, n_run, idle_cnt, cs_bad;
  int          order [16];
  logic [15:0] exp_tx [16];
  logic [15:0] rep    [16];
  logic [3:0]  exp_cs [16];
  bit          cont_a [16];
  logic [3:0]  cur_idle;
  logic [15:0] cap, mask;
  realtime     last_t, min_gap;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_miso();
    int k, b;
    k = smp / w;
    b = smp % w;
    if (k < n_run) miso = rep[order[k]][w-1-b];
    else miso = 1'b0;
  endtask

  always @(sck) begin : slave_p
    logic lead;
    int   e;
    if (active) begin
      #1;
      if (last_t >= 0 && ($realtime - last_t) < min_gap) min_gap = $realtime - last_t;
      last_t = $realtime;
      lead = (sck != m_cpol);
      if (lead != m_cpha && smp < n_run * w) begin
        e = order[smp / w];
        if (cs !== exp_cs[e]) cs_bad++;
        cap = {cap[14:0], mosi};
        if (smp % w == w - 1)
          chk($sformatf("R3 mosi word of entry %0d", e), 32'(cap & mask), 32'(exp_tx[e] & mask));
        smp++;
        set_miso();
      end
    end
  end

  always @(cs) begin
    if (active) begin
      #1;
      if (cs === cur_idle) idle_cnt++;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_queue(int seed, int baud, bit cpol, bit cpha, bit wide, int st, int en);
    int          n, exp_idle;
    logic [15:0] d;
    logic [3:0]  c;
    w = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    m_cpol = cpol; m_cpha = cpha;
    cur_idle = 4'(seed * 7 + 15);
    wr(6'h30, {5'b0, wide, cpha, cpol, 8'(baud)});
    wr(6'h31, {4'b0, cur_idle, 4'(en), 4'(st)});
    for (int i = 0; i < 16; i++) begin
      exp_tx[i] = 16'(i * 16'h3B1D + seed * 16'h0A57 + 16'h5A0F);
      rep[i]    = 16'((exp_tx[i] * 16'h0005) ^ 16'hC3A5);
      c = 4'(i * 3 + seed);
      if (c == cur_idle) c = ~cur_idle;
      exp_cs[i] = c;
      cont_a[i] = ((i + seed) % 3) == 0;
      wr(6'(i), exp_tx[i]);
      wr(6'(32 + i), {11'b0, cont_a[i], c});
    end
    n = ((en - st) & 15) + 1;
    for (int k = 0; k < 16; k++) order[k] = (st + k) & 15;
    exp_idle = 1;
    for (int k = 0; k < n - 1; k++) if (!cont_a[order[k]]) exp_idle++;
    n_run = n; smp = 0; cap = '0; idle_cnt = 0; cs_bad = 0;
    last_t = -1.0; min_gap = 1.0e9;
    set_miso();
    active = 1'b1;
    wr(6'h32, 16'h0001);
    do rd(6'h32, d); while (d !== 16'h0001);
    repeat (3) @(negedge clk);
    active = 1'b0;
    #2;
    rd(6'h32, d);
    chk("R5 status done, not busy", 32'(d), 32'h1);
    chk("R5 selects back to idle", 32'(cs), 32'(cur_idle));
    chk("R7 sck rests at CPOL", 32'(sck), 32'(cpol));
    chk("R3 sample edge count", 32'(smp), 32'(n * w));
    chk("R2 select pattern mismatches", 32'(cs_bad), 32'h0);
    chk("R8 returns to idle selects", 32'(idle_cnt), 32'(exp_idle));
    chk("R6 half period in ns", 32'(int'(min_gap)), 32'(40 * baud));
    for (int k = 0; k < n; k++) begin
      rd(6'(16 + order[k]), d);
      chk($sformatf("R4 receive slot %0d", order[k]), 32'(d), 32'(rep[order[k]] & mask));
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(6'h32, d); chk("R1 status after reset", 32'(d), 32'h0);
    rd(6'h30, d); chk("R1 config after reset", 32'(d), 32'h0);
    rd(6'h31, d); chk("R1 queue after reset", 32'(d), 32'h0F00);
    chk("R1 sck after reset", 32'(sck), 32'h0);
    chk("R1 mosi after reset", 32'(mosi), 32'h0);
    chk("R1 selects after reset", 32'(cs), 32'hF);

    // R7: four modes x two word sizes, R5: full, partial, wrap, single
    run_queue(1, 1, 1'b0, 1'b0, 1'b1, 0, 15);
    run_queue(2, 2, 1'b0, 1'b1, 1'b0, 3, 7);
    run_queue(3, 1, 1'b1, 1'b0, 1'b1, 13, 2);
    run_queue(4, 3, 1'b1, 1'b1, 1'b0, 9, 9);
    run_queue(5, 2, 1'b1, 1'b1, 1'b1, 5, 12);
    run_queue(6, 1, 1'b0, 1'b0, 1'b0, 14, 1);
    run_queue(7, 2, 1'b1, 1'b0, 1'b0, 0, 5);
    run_queue(8, 1, 1'b0, 1'b1, 1'b1, 8, 15);

    // R6: zero rate refuses start, R9: status read-back
    wr(6'h30, 16'h0100);
    wr(6'h32, 16'h0001);
    repeat (10) @(negedge clk);
    rd(6'h32, d); chk("R6 start ignored at zero rate", 32'(d), 32'h1);
    chk("R6 sck idle at zero rate", 32'(sck), 32'h1);
    rd(6'h30, d); chk("R9 config read-back", 32'(d), 32'h0100);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule